// File: doc/BRIEF.md
# Processor Event Arbiter

This block sits beside a small processor's bus sequencer and settles what happens at each boundary the sequencer reports. At the end of a machine cycle it may hand the external bus to another master. At the end of an instruction it chooses between the non-maskable interrupt, the maskable interrupt and carrying on. After a halt instruction it keeps the sequencer issuing dummy fetches, whose data is replaced by a no-operation, until an acceptable interrupt arrives.

The block owns the interrupt enable state (a live bit plus a backup bit), the vectoring mode and the 8-bit page register used for table-based vectoring. When it accepts an interrupt it raises a one-cycle acknowledge, reports the kind of interrupt and presents the target address. The sequencer then uses these to run the acknowledge cycle and stack the program counter. Both of those tasks belong to the sequencer, not to this block.

Top module: `core_event_arbiter`

## Requirements
- R1: After reset, busAck, haltOut, forceNop and ackValid are 0, ackType is 2'b00 and vectorAddr is 16'h0000. The interrupt enable is clear, the vectoring mode is 0 and the page register holds 8'h00.
- R2: busAck rises after the clock edge that samples busReq high while mcycEnd is high. A busReq without mcycEnd does not grant the bus. Once granted, busAck falls after the first edge that samples busReq low.
- R3: No interrupt is accepted at an edge where busReq or busAck is high.
- R4: intReq is level sensitive. It is accepted at an instrEnd edge only when the enable is set, and it reports ackType 2'b10.
- R5: A rising edge on nmiReq is latched until it is serviced. It is accepted whatever the enable is, and it wins over intReq. It reports ackType 2'b01 and vectorAddr 16'h0066. Holding nmiReq high does not trigger it again.
- R6: eiCmd sets both the enable and its backup, and diCmd clears both. Accepting an NMI clears only the enable, and retnCmd copies the backup into the enable. Accepting an INT clears both bits.
- R7: A haltExec strobe raises haltOut and forceNop on the next edge. While halted, instrEnd does not sample interrupts and t4Strobe does. Halt ends on the same edge that accepts the interrupt.
- R8: In mode 1 (modeSel 2'b01) an INT reports vectorAddr 16'h0038.
- R9: In mode 2 (modeSel 2'b10) an INT reports vectorAddr {page register, devVector}. The page register is loaded from iData by iLoad.
- R10: In mode 0 an INT reports vectorAddr {10'b0, devVector[5:3], 3'b000}, which is the restart target of the byte the device supplies.
- R11: modeSet with modeSel 2'b11 is ignored and the current mode is kept.
- R12: ackValid is high for exactly one cycle per accepted interrupt. ackType and vectorAddr hold until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | Non-maskable request, edge detected |
| intReq | input | 1 | Maskable request, level |
| busReq | input | 1 | External bus request |
| mcycEnd | input | 1 | Last clock of a machine cycle |
| instrEnd | input | 1 | Last clock of an instruction |
| t4Strobe | input | 1 | Fourth state of a fetch, used while halted |
| haltExec | input | 1 | Halt instruction executed |
| eiCmd | input | 1 | Enable interrupts |
| diCmd | input | 1 | Disable interrupts |
| retnCmd | input | 1 | Return from NMI, restore enable |
| modeSet | input | 1 | Load vectoring mode |
| modeSel | input | 2 | New vectoring mode |
| iLoad | input | 1 | Load page register |
| iData | input | 8 | Page register value |
| devVector | input | 8 | Byte supplied by the interrupting device |
| busAck | output | 1 | Bus granted |
| haltOut | output | 1 | Halted status |
| forceNop | output | 1 | Replace fetched byte by a no-operation |
| ackValid | output | 1 | Interrupt accepted, one-cycle pulse |
| ackType | output | 2 | 01 NMI, 10 INT, 00 none yet |
| vectorAddr | output | 16 | Target address of the accepted interrupt |

## Verification
The bench raises an NMI while the bus is granted and then releases the bus. A design that failed to latch the edge would lose that NMI, and one that ignored the grant would take it early. It checks that an NMI accepted with INT also pending leaves INT blocked until retnCmd restores the enable, and that an INT acceptance destroys the backup. A design that copied the enable wrongly would take a second INT or miss a legitimate one. While halted, the bench pulses instrEnd with an enabled INT pending and expects nothing until t4Strobe. It also asks for mode 3 and expects the mode-1 target to remain, so a decoder that fell through to another mode would show a wrong address.

// File: rtl/core_event_pkg.sv
package core_event_pkg;

  typedef enum logic [1:0] {
    ACK_NONE = 2'b00,
    ACK_NMI  = 2'b01,
    ACK_INT  = 2'b10
  } ackKind_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic takeNmi;
    logic takeInt;
    logic enSet;
    logic enClr;
    logic enRestore;
  } evStrobe_t;

endpackage

// File: rtl/event_ctrl.sv
module event_ctrl
  import core_event_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      nmiReq,
  input  logic      intReq,
  input  logic      busReq,
  input  logic      mcycEnd,
  input  logic      instrEnd,
  input  logic      t4Strobe,
  input  logic      haltExec,
  input  logic      eiCmd,
  input  logic      diCmd,
  input  logic      retnCmd,
  input  logic      iffOpen,
  output evStrobe_t stb,
  output logic      busAck,
  output logic      halted,
  output logic      ackValid
);

  logic nmiPrev;
  logic nmiPend;
  logic sampleNow;
  logic busBusy;
  logic takeNmi;
  logic takeInt;
  logic anyTake;

  // while halted only the T4 state of the dummy fetch samples the lines
  assign sampleNow = halted ? t4Strobe : instrEnd;
  assign busBusy   = busReq | busAck;
  assign takeNmi   = sampleNow & ~busBusy & nmiPend;
  assign takeInt   = sampleNow & ~busBusy & ~nmiPend & intReq & iffOpen;
  assign anyTake   = takeNmi | takeInt;

  always_comb begin
    stb.takeNmi   = takeNmi;
    stb.takeInt   = takeInt;
    stb.enClr     = diCmd & ~anyTake;
    stb.enSet     = eiCmd & ~diCmd & ~anyTake;
    stb.enRestore = retnCmd & ~eiCmd & ~diCmd & ~anyTake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev  <= 1'b0;
      nmiPend  <= 1'b0;
      busAck   <= 1'b0;
      halted   <= 1'b0;
      ackValid <= 1'b0;
    end else begin
      nmiPrev  <= nmiReq;
      nmiPend  <= (nmiPend & ~takeNmi) | (nmiReq & ~nmiPrev);
      ackValid <= anyTake;
      if (!busAck) busAck <= mcycEnd & busReq;
      else         busAck <= busReq;
      if (anyTake)       halted <= 1'b0;
      else if (haltExec) halted <= 1'b1;
    end
  end

  assert_grant_sampled_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAck) |-> $past(busReq && mcycEnd));

  assert_no_ack_when_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(!busReq && !busAck));

  assert_halt_exit_acked_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halted) |-> ackValid);

endmodule

// File: rtl/event_dpath.sv
module event_dpath
  import core_event_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          ADDR_W  = 2 * DATA_W,
  parameter logic [15:0] NMI_VEC = 16'h0066,
  parameter logic [15:0] RST_VEC = 16'h0038
) (
  input  logic              clk,
  input  logic              rstN,
  input  evStrobe_t         stb,
  input  logic              modeSet,
  input  logic [1:0]        modeSel,
  input  logic              iLoad,
  input  logic [DATA_W-1:0] iData,
  input  logic [DATA_W-1:0] devVector,
  output logic              iffOpen,
  output ackKind_e          ackType,
  output logic [ADDR_W-1:0] vectorAddr
);

  localparam int PAD0_W = ADDR_W - 6;
  localparam int PAD2_W = ADDR_W - 2 * DATA_W;

  logic              iffBackup;
  logic [1:0]        intMode;
  logic [DATA_W-1:0] pageReg;
  logic [ADDR_W-1:0] intTarget;

  always_comb begin
    case (intMode)
      2'b01:   intTarget = ADDR_W'(RST_VEC);
      2'b10:   intTarget = {{PAD2_W{1'b0}}, pageReg, devVector};
      default: intTarget = {{PAD0_W{1'b0}}, devVector[5:3], 3'b000};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iffOpen    <= 1'b0;
      iffBackup  <= 1'b0;
      intMode    <= 2'b00;
      pageReg    <= '0;
      ackType    <= ACK_NONE;
      vectorAddr <= '0;
    end else begin
      if (stb.takeNmi) begin
        iffOpen    <= 1'b0;
        ackType    <= ACK_NMI;
        vectorAddr <= ADDR_W'(NMI_VEC);
      end else if (stb.takeInt) begin
        iffOpen    <= 1'b0;
        iffBackup  <= 1'b0;
        ackType    <= ACK_INT;
        vectorAddr <= intTarget;
      end else if (stb.enClr) begin
        iffOpen   <= 1'b0;
        iffBackup <= 1'b0;
      end else if (stb.enSet) begin
        iffOpen   <= 1'b1;
        iffBackup <= 1'b1;
      end else if (stb.enRestore) begin
        iffOpen <= iffBackup;
      end
      if (modeSet && modeSel != 2'b11) intMode <= modeSel;
      if (iLoad) pageReg <= iData;
    end
  end

  assert_take_closes_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeNmi || stb.takeInt) |=> !iffOpen);

  assert_mode3_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (modeSet && modeSel == 2'b11) |=> $stable(intMode));

  assert_nmi_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeNmi |=> (ackType == ACK_NMI && vectorAddr == ADDR_W'(NMI_VEC)));

endmodule

// File: rtl/core_event_arbiter.sv
module core_event_arbiter
  import core_event_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  nmiReq,
  input  logic                  intReq,
  input  logic                  busReq,
  input  logic                  mcycEnd,
  input  logic                  instrEnd,
  input  logic                  t4Strobe,
  input  logic                  haltExec,
  input  logic                  eiCmd,
  input  logic                  diCmd,
  input  logic                  retnCmd,
  input  logic                  modeSet,
  input  logic [1:0]            modeSel,
  input  logic                  iLoad,
  input  logic [DATA_W-1:0]     iData,
  input  logic [DATA_W-1:0]     devVector,
  output logic                  busAck,
  output logic                  haltOut,
  output logic                  forceNop,
  output logic                  ackValid,
  output logic [1:0]            ackType,
  output logic [2*DATA_W-1:0]   vectorAddr
);

  localparam int ADDR_W = 2 * DATA_W;

  evStrobe_t stb;
  logic      iffOpen;
  logic      halted;
  ackKind_e  ackKind;

  event_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .nmiReq   (nmiReq),
    .intReq   (intReq),
    .busReq   (busReq),
    .mcycEnd  (mcycEnd),
    .instrEnd (instrEnd),
    .t4Strobe (t4Strobe),
    .haltExec (haltExec),
    .eiCmd    (eiCmd),
    .diCmd    (diCmd),
    .retnCmd  (retnCmd),
    .iffOpen  (iffOpen),
    .stb      (stb),
    .busAck   (busAck),
    .halted   (halted),
    .ackValid (ackValid)
  );

  event_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .modeSet    (modeSet),
    .modeSel    (modeSel),
    .iLoad      (iLoad),
    .iData      (iData),
    .devVector  (devVector),
    .iffOpen    (iffOpen),
    .ackType    (ackKind),
    .vectorAddr (vectorAddr)
  );

  assign haltOut  = halted;
  assign forceNop = halted;
  assign ackType  = ackKind;

  assert_nmi_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeInt) |-> !stb.takeNmi && !busReq);

endmodule

// File: tb/test_core_event_arbiter.sv
module test_core_event_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic nmiReq = 0, intReq = 0, busReq = 0, mcycEnd = 0, instrEnd = 0, t4Strobe = 0;
  logic haltExec = 0, eiCmd = 0, diCmd = 0, retnCmd = 0, modeSet = 0, iLoad = 0;
  logic [1:0]  modeSel = 0;
  logic [7:0]  iData = 0, devVector = 0;
  logic        busAck, haltOut, forceNop, ackValid;
  logic [1:0]  ackType;
  logic [15:0] vectorAddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  core_event_arbiter i_core_event_arbiter (
    .clk(clk), .rstN(rstN), .nmiReq(nmiReq), .intReq(intReq), .busReq(busReq),
    .mcycEnd(mcycEnd), .instrEnd(instrEnd), .t4Strobe(t4Strobe), .haltExec(haltExec),
    .eiCmd(eiCmd), .diCmd(diCmd), .retnCmd(retnCmd), .modeSet(modeSet), .modeSel(modeSel),
    .iLoad(iLoad), .iData(iData), .devVector(devVector), .busAck(busAck),
    .haltOut(haltOut), .forceNop(forceNop), .ackValid(ackValid), .ackType(ackType),
    .vectorAddr(vectorAddr)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doEi();     eiCmd = 1;   step(); eiCmd = 0;   endtask
  task automatic doDi();     diCmd = 1;   step(); diCmd = 0;   endtask
  task automatic doRetn();   retnCmd = 1; step(); retnCmd = 0; endtask
  task automatic doInstr();  instrEnd = 1; mcycEnd = 1; step(); instrEnd = 0; mcycEnd = 0; endtask
  task automatic doT4();     t4Strobe = 1; step(); t4Strobe = 0; endtask
  task automatic doHalt();   haltExec = 1; step(); haltExec = 0; endtask
  task automatic nmiEdge();  nmiReq = 1; step(); nmiReq = 0; step(); endtask
  task automatic setMode(input logic [1:0] m); modeSel = m; modeSet = 1; step(); modeSet = 0; endtask

  // take an INT and check pulse shape and target
  task automatic expectInt(input string tag, input logic [15:0] vec);
    doInstr();
    chk({tag, " ackValid"}, 16'(ackValid), 16'd1);
    chk({tag, " ackType"}, 16'(ackType), 16'd2);
    chk({tag, " vectorAddr"}, vectorAddr, vec);
    step();
    chk("R12 ackValid one cycle", 16'(ackValid), 16'd0);
  endtask

  task automatic t_reset();
    chk("R1 busAck", 16'(busAck), 0);
    chk("R1 haltOut", 16'(haltOut), 0);
    chk("R1 forceNop", 16'(forceNop), 0);
    chk("R1 ackValid", 16'(ackValid), 0);
    chk("R1 ackType", 16'(ackType), 0);
    chk("R1 vectorAddr", vectorAddr, 16'h0000);
    intReq = 1;
    doInstr();
    chk("R1 enable clear, R4 masked", 16'(ackValid), 0);
    intReq = 0;
  endtask

  task automatic t_modes();
    // mode 0 after reset: restart target from devVector bits 5:3
    doEi(); intReq = 1; devVector = 8'hD7;
    expectInt("R1 R10 mode0", 16'h0010);
    intReq = 0;
    setMode(2'b10);
    doEi(); intReq = 1; devVector = 8'h44;
    expectInt("R1 page reset R9", 16'h0044);
    intReq = 0;
    iData = 8'h12; iLoad = 1; step(); iLoad = 0;
    doEi(); intReq = 1; devVector = 8'hA5;
    expectInt("R9 mode2", 16'h12A5);
    intReq = 0;
    setMode(2'b01);
    doEi(); intReq = 1;
    expectInt("R8 mode1", 16'h0038);
    intReq = 0;
    setMode(2'b11);
    doEi(); intReq = 1; devVector = 8'h00;
    expectInt("R11 mode3 ignored", 16'h0038);
    intReq = 0;
  endtask

  task automatic t_bus();
    doEi(); intReq = 1; busReq = 1;
    step();
    chk("R2 no grant without mcycEnd", 16'(busAck), 0);
    instrEnd = 1; mcycEnd = 1; step(); instrEnd = 0; mcycEnd = 0;
    chk("R2 grant", 16'(busAck), 1);
    chk("R3 busReq blocks INT", 16'(ackValid), 0);
    doInstr();
    chk("R3 busAck blocks INT", 16'(ackValid), 0);
    nmiReq = 1; step();
    busReq = 0; step();
    chk("R2 release", 16'(busAck), 0);
    nmiReq = 0;
    doInstr();
    chk("R5 latched NMI ackValid", 16'(ackValid), 1);
    chk("R5 NMI over INT type", 16'(ackType), 16'd1);
    chk("R5 NMI target", vectorAddr, 16'h0066);
    doInstr();
    chk("R6 NMI closes enable", 16'(ackValid), 0);
    doRetn();
    expectInt("R6 retn restores", 16'h0038);
    intReq = 0;
  endtask

  task automatic t_enable();
    doEi(); doDi(); intReq = 1;
    doInstr();
    chk("R6 di clears", 16'(ackValid), 0);
    doEi();
    expectInt("R4 level INT", 16'h0038);
    doRetn();
    doInstr();
    chk("R6 INT clears backup", 16'(ackValid), 0);
    intReq = 0;
    nmiReq = 1; step();
    doInstr();
    chk("R5 unmaskable NMI", 16'(ackType), 16'd1);
    chk("R5 unmaskable NMI valid", 16'(ackValid), 1);
    doInstr();
    chk("R5 held high no retrigger", 16'(ackValid), 0);
    nmiReq = 0; step();
  endtask

  task automatic t_halt();
    doEi(); doHalt();
    chk("R7 haltOut", 16'(haltOut), 1);
    chk("R7 forceNop", 16'(forceNop), 1);
    intReq = 1;
    doInstr();
    chk("R7 instrEnd ignored when halted", 16'(ackValid), 0);
    chk("R7 still halted", 16'(haltOut), 1);
    doT4();
    chk("R7 T4 accepts", 16'(ackValid), 1);
    chk("R7 INT type", 16'(ackType), 16'd2);
    chk("R8 halt exit target", vectorAddr, 16'h0038);
    chk("R7 halt exits", 16'(haltOut), 0);
    doHalt();
    doT4();
    chk("R4 masked stays halted", 16'(haltOut), 1);
    chk("R4 masked no ack", 16'(ackValid), 0);
    nmiEdge();
    doT4();
    chk("R5 NMI exits halt", 16'(ackType), 16'd1);
    chk("R7 NMI exit", 16'(haltOut), 0);
    doEi(); doHalt(); nmiEdge();
    doT4();
    chk("R5 NMI beats INT in halt", 16'(ackType), 16'd1);
    chk("R5 NMI beats INT valid", 16'(ackValid), 1);
    intReq = 0; step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_bus();
    t_enable();
    t_halt();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R12 actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule